// File: doc/BRIEF.md
# Miss Tracking Registers for a Non-Blocking Data Cache

This block records the load misses that a non-blocking data cache still has outstanding, grouped by cache line. The first miss to a line that is not already tracked takes a free entry. The block then sends one refill request for that line to memory, tagged with the entry number. Any later miss to the same line goes into that entry's slot for its word position, and no second memory request is made. A slot holds the load's destination tag and how to shape the result: access width, byte position inside the word, and signed or unsigned. The word position is not stored in the slot, because the slot's index already gives it.

Refill responses carry the entry number and a whole line of data, and they may come back in any order. When a line arrives, the block sends the waiting loads out one per cycle, each with its destination tag and its value already extracted and extended. After the last waiting load of that line has gone out, the entry is free again. The block raises stall when it cannot take the miss being presented. That happens when no entry is free for a new line, or when the word slot the miss needs is already taken.

Top module: `miss_tracker`

## Requirements
- R1: After reset, with no miss presented, `stall`, `done_valid` and `refill_req_valid` are all low.
- R2: A miss to a line that no live entry holds, when an entry is free, is accepted (stall low). It takes the lowest-numbered free entry. On the next cycle `refill_req_valid` is high for one cycle, carrying the line address (address bits 31:5) and that entry number.
- R3: A miss to a live entry's line whose word slot (address bits 4:2) is empty is accepted without any new refill request. It is replayed later from that entry's refill data.
- R4: A miss to an untracked line while all 4 entries are live raises `stall` in the same cycle. Nothing is allocated and no request is issued.
- R5: A miss to a live entry's line whose word slot is already occupied raises `stall` in the same cycle.
- R6: A refill response captured at clock edge k gives the first completion at edge k+1. Further completions follow on each consecutive edge, lowest word slot first, until every occupied slot of that entry has been sent. The entry is freed at the edge that sends its last completion. Every accepted load completes exactly once.
- R7: Result format. The access width is given by the size field: 0 = byte, 1 = halfword, 2 = word. A byte is taken at byte offset address bits 1:0. A halfword is taken from the half selected by address bit 1. A byte or halfword is sign-extended to 32 bits when the signed bit is set and zero-extended otherwise. A word is returned unchanged.
- R8: Refill responses may arrive in any order relative to the requests. Each one is applied to the entry named by its id.
- R9: A miss that arrives in the same cycle as the last completion of the matching entry is handled as a new primary miss. It allocates a free entry and issues a new refill request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | A load miss is presented |
| miss_addr | input | 32 | Byte address of the missing load |
| miss_dest | input | 6 | Destination register tag |
| miss_size | input | 2 | Access width: 0 byte, 1 halfword, 2 word |
| miss_signed | input | 1 | Sign-extend sub-word results |
| stall | output | 1 | The presented miss cannot be accepted this cycle |
| refill_req_valid | output | 1 | Refill request strobe |
| refill_req_line | output | 27 | Line address to fetch |
| refill_req_id | output | 2 | Entry number to return with the response |
| refill_rsp_valid | input | 1 | Refill response strobe |
| refill_rsp_id | input | 2 | Entry the response belongs to |
| refill_rsp_data | input | 256 | Whole line, word 0 in the low bits |
| done_valid | output | 1 | A replayed load completes |
| done_dest | output | 6 | Destination tag of the completing load |
| done_data | output | 32 | Extracted and extended load value |

## Verification
Stall is combinational, so the bench drives a miss just after a falling edge, waits a short delay, and reads stall before the next rising edge. The refill request comes out of a register. The bench therefore looks for it at the falling edge one clock after the miss is accepted, and a secondary miss is shown to have caused no request at that same point. Completions start the edge after the response is captured and come one per edge after that. The directed cases count edges from the response to check the latency, the slot order and the same-cycle free. In the random phase, every completion is matched by destination tag against a value the bench computes from its own line-data function, and at the end the bench checks that no accepted load is still missing its completion.

// File: rtl/mt_pkg.sv
// Shared encodings for the miss tracker.
// Assumes nothing beyond the size field encoding used at the ports.
package mt_pkg;
    typedef enum logic [1:0] {
        LD_BYTE = 2'd0,
        LD_HALF = 2'd1,
        LD_WORD = 2'd2
    } ld_size_e;
endpackage

// File: rtl/mt_lookup.sv
// Parallel line-address compare across all entries plus free-entry pick.
// Assumes at most one live entry holds any line; an entry that is being
// freed this cycle is excluded from matching so a new miss reallocates.
module mt_lookup #(
    parameter int N_ENT  = 4,
    parameter int LINE_W = 27
) (
    input  logic [N_ENT-1:0]          ent_valid,
    input  logic [N_ENT-1:0]          ent_freeing,
    input  logic [N_ENT*LINE_W-1:0]   ent_lines,
    input  logic [LINE_W-1:0]         probe_line,
    output logic                      hit,
    output logic [$clog2(N_ENT)-1:0]  hit_idx,
    output logic                      any_free,
    output logic [$clog2(N_ENT)-1:0]  free_idx
);
    localparam int IDX_W = $clog2(N_ENT);

    logic [N_ENT-1:0] match;

    // One comparator per entry, all evaluated in parallel.
    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign match[g] = ent_valid[g] && !ent_freeing[g]
                          && (ent_lines[g*LINE_W +: LINE_W] == probe_line);
    end

    // Encode the matching entry and the lowest free entry.
    always_comb begin
        hit      = |match;
        any_free = ~&ent_valid;
        hit_idx  = '0;
        free_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (match[i])      hit_idx  = IDX_W'(i);
            if (!ent_valid[i]) free_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/mt_format.sv
// Shapes a loaded word into the register value: byte or halfword pick at
// the recorded offset, then sign or zero extension; words pass through.
// Assumes DATA_W is a power of two of at least 32 bits.
module mt_format
    import mt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]             word,
    input  logic [1:0]                    size,
    input  logic                          sign_ext,
    input  logic [$clog2(DATA_W/8)-1:0]   byte_off,
    output logic [DATA_W-1:0]             value
);
    localparam int BOFF_W = $clog2(DATA_W/8);

    logic [7:0]  sel_b;
    logic [15:0] sel_h;

    // Select the addressed byte and halfword, then extend per size.
    always_comb begin
        sel_b = 8'(word >> {byte_off, 3'b000});
        sel_h = 16'(word >> {byte_off[BOFF_W-1:1], 4'b0000});
        case (ld_size_e'(size))
            LD_BYTE: value = {{(DATA_W-8){sign_ext & sel_b[7]}}, sel_b};
            LD_HALF: value = {{(DATA_W-16){sign_ext & sel_h[15]}}, sel_h};
            default: value = word;
        endcase
    end
endmodule

// File: rtl/miss_tracker.sv
// Miss tracking file with one slot per word of the line in every entry.
// The word offset of a waiting load is the slot index. A primary miss
// allocates an entry and requests a refill; a secondary miss fills a slot.
// On refill, occupied slots are replayed one per cycle, lowest first, and
// the entry frees with the last one. Assumes responses only name entries
// that have an outstanding request.
module miss_tracker #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int WORD_BYTES = 4,
    parameter int N_ENT      = 4,
    parameter int TAG_W      = 6
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   miss_valid,
    input  logic [ADDR_W-1:0]                      miss_addr,
    input  logic [TAG_W-1:0]                       miss_dest,
    input  logic [1:0]                             miss_size,
    input  logic                                   miss_signed,
    output logic                                   stall,
    output logic                                   refill_req_valid,
    output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   refill_req_line,
    output logic [$clog2(N_ENT)-1:0]               refill_req_id,
    input  logic                                   refill_rsp_valid,
    input  logic [$clog2(N_ENT)-1:0]               refill_rsp_id,
    input  logic [LINE_BYTES*8-1:0]                refill_rsp_data,
    output logic                                   done_valid,
    output logic [TAG_W-1:0]                       done_dest,
    output logic [WORD_BYTES*8-1:0]                done_data
);
    localparam int WORDS     = LINE_BYTES / WORD_BYTES;
    localparam int BOFF_W    = $clog2(WORD_BYTES);
    localparam int WIDX_W    = $clog2(WORDS);
    localparam int LINE_W    = ADDR_W - $clog2(LINE_BYTES);
    localparam int IDX_W     = $clog2(N_ENT);
    localparam int DATA_W    = WORD_BYTES * 8;
    localparam int LINE_BITS = LINE_BYTES * 8;

    // Entry state
    logic [N_ENT-1:0]     ent_valid, ent_filled;
    logic [LINE_W-1:0]    ent_line [N_ENT];
    logic [LINE_BITS-1:0] ent_data [N_ENT];
    logic [WORDS-1:0]     sub_valid [N_ENT];
    logic [TAG_W-1:0]     sub_dest  [N_ENT][WORDS];
    logic [1:0]           sub_size  [N_ENT][WORDS];
    logic                 sub_sgn   [N_ENT][WORDS];
    logic [BOFF_W-1:0]    sub_boff  [N_ENT][WORDS];

    // Replay engine state
    logic                 rp_lock;
    logic [IDX_W-1:0]     rp_lock_idx;
    logic                 rp_go, rp_last;
    logic [IDX_W-1:0]     rp_idx;
    logic [WIDX_W-1:0]    rp_slot;
    logic [N_ENT-1:0]     ent_freeing;
    logic [DATA_W-1:0]    rp_value;

    // Miss decode
    logic [LINE_W-1:0]    m_line;
    logic [WIDX_W-1:0]    m_widx;
    logic [BOFF_W-1:0]    m_boff;
    logic                 hit, any_free, slot_busy, do_alloc, do_attach;
    logic [IDX_W-1:0]     hit_idx, free_idx;
    logic [N_ENT*LINE_W-1:0] lines_flat;

    assign m_line = miss_addr[ADDR_W-1 -: LINE_W];
    assign m_widx = miss_addr[BOFF_W +: WIDX_W];
    assign m_boff = miss_addr[BOFF_W-1:0];

    for (genvar g = 0; g < N_ENT; g++) begin : g_flat
        assign lines_flat[g*LINE_W +: LINE_W] = ent_line[g];
    end

    mt_lookup #(.N_ENT(N_ENT), .LINE_W(LINE_W)) u_lookup (
        .ent_valid   (ent_valid),
        .ent_freeing (ent_freeing),
        .ent_lines   (lines_flat),
        .probe_line  (m_line),
        .hit         (hit),
        .hit_idx     (hit_idx),
        .any_free    (any_free),
        .free_idx    (free_idx)
    );

    // Decide between attach, allocate and stall for the presented miss.
    always_comb begin
        slot_busy = sub_valid[hit_idx][m_widx];
        stall     = miss_valid && (hit ? slot_busy : !any_free);
        do_attach = miss_valid && hit && !slot_busy;
        do_alloc  = miss_valid && !hit && any_free;
    end

    // Pick the entry to replay: the locked one, else the lowest filled.
    always_comb begin
        rp_go  = rp_lock;
        rp_idx = rp_lock_idx;
        if (!rp_lock) begin
            for (int i = N_ENT - 1; i >= 0; i--) begin
                if (ent_filled[i]) begin
                    rp_go  = 1'b1;
                    rp_idx = IDX_W'(i);
                end
            end
        end
    end

    // Pick the lowest occupied slot and flag whether it is the last one.
    always_comb begin
        rp_slot = '0;
        for (int w = WORDS - 1; w >= 0; w--) begin
            if (sub_valid[rp_idx][w]) rp_slot = WIDX_W'(w);
        end
        rp_last = ($countones(sub_valid[rp_idx]) == 1);
        for (int i = 0; i < N_ENT; i++) begin
            ent_freeing[i] = rp_go && rp_last && (rp_idx == IDX_W'(i));
        end
    end

    mt_format #(.DATA_W(DATA_W)) u_format (
        .word     (ent_data[rp_idx][rp_slot*DATA_W +: DATA_W]),
        .size     (sub_size[rp_idx][rp_slot]),
        .sign_ext (sub_sgn[rp_idx][rp_slot]),
        .byte_off (sub_boff[rp_idx][rp_slot]),
        .value    (rp_value)
    );

    // Control state: entry valid/filled flags, slot flags and replay lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid   <= '0;
            ent_filled  <= '0;
            rp_lock     <= 1'b0;
            rp_lock_idx <= '0;
            for (int i = 0; i < N_ENT; i++) sub_valid[i] <= '0;
        end else begin
            for (int i = 0; i < N_ENT; i++) begin
                if (ent_freeing[i]) begin
                    ent_valid[i]  <= 1'b0;
                    ent_filled[i] <= 1'b0;
                end
            end
            if (refill_rsp_valid) ent_filled[refill_rsp_id] <= 1'b1;
            if (rp_go) begin
                sub_valid[rp_idx][rp_slot] <= 1'b0;
                rp_lock     <= !rp_last;
                rp_lock_idx <= rp_idx;
            end
            if (do_alloc) begin
                ent_valid[free_idx]  <= 1'b1;
                ent_filled[free_idx] <= 1'b0;
                sub_valid[free_idx]  <= WORDS'(1) << m_widx;
            end
            if (do_attach) sub_valid[hit_idx][m_widx] <= 1'b1;
        end
    end

    // Payload storage: line tags, refill data and per-slot load format.
    always_ff @(posedge clk) begin
        if (refill_rsp_valid) ent_data[refill_rsp_id] <= refill_rsp_data;
        if (do_alloc) ent_line[free_idx] <= m_line;
        if (do_alloc || do_attach) begin
            sub_dest[do_alloc ? free_idx : hit_idx][m_widx] <= miss_dest;
            sub_size[do_alloc ? free_idx : hit_idx][m_widx] <= miss_size;
            sub_sgn [do_alloc ? free_idx : hit_idx][m_widx] <= miss_signed;
            sub_boff[do_alloc ? free_idx : hit_idx][m_widx] <= m_boff;
        end
    end

    // Registered outputs: refill request and load completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refill_req_valid <= 1'b0;
            refill_req_line  <= '0;
            refill_req_id    <= '0;
            done_valid       <= 1'b0;
            done_dest        <= '0;
            done_data        <= '0;
        end else begin
            refill_req_valid <= do_alloc;
            refill_req_line  <= m_line;
            refill_req_id    <= free_idx;
            done_valid       <= rp_go;
            done_dest        <= sub_dest[rp_idx][rp_slot];
            done_data        <= rp_value;
        end
    end

    // R2
    req_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req_valid |-> $past(miss_valid && !stall));

    // R4
    no_req_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && stall) |=> !refill_req_valid);

    // R8
    rsp_target_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refill_rsp_valid |-> (ent_valid[refill_rsp_id] && !ent_filled[refill_rsp_id]));

    // R6
    done_from_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> $past(|ent_filled));

    // R6
    one_replay_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rp_lock |-> ent_filled[rp_lock_idx]);

    // R2
    for (genvar a = 0; a < N_ENT; a++) begin : g_pair_a
        for (genvar b = a + 1; b < N_ENT; b++) begin : g_pair_b
            unique_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (ent_valid[a] && ent_valid[b]) |-> (ent_line[a] != ent_line[b]));
        end
    end
endmodule

// File: tb/sim_miss_tracker.sv
// Self-checking bench: directed corner cases, then seeded random traffic
// with a bench-side memory that answers refills in random order.
module sim_miss_tracker;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         miss_valid = 1'b0;
    logic [31:0]  miss_addr = '0;
    logic [5:0]   miss_dest = '0;
    logic [1:0]   miss_size = '0;
    logic         miss_signed = 1'b0;
    logic         stall;
    logic         refill_req_valid;
    logic [26:0]  refill_req_line;
    logic [1:0]   refill_req_id;
    logic         refill_rsp_valid = 1'b0;
    logic [1:0]   refill_rsp_id = '0;
    logic [255:0] refill_rsp_data = '0;
    logic         done_valid;
    logic [5:0]   done_dest;
    logic [31:0]  done_data;

    int n_chk = 0;
    int n_fail = 0;

    // bench model
    bit          exp_v   [64];
    logic [26:0] exp_line[64];
    int          exp_w   [64];
    logic [31:0] exp_val [64];
    bit          pend    [4];
    logic [26:0] pend_line[4];

    miss_tracker u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mem_word(logic [26:0] line, int w);
        return ({line, 5'b0} * 32'h9E3779B1) ^ (32'(w + 3) * 32'h7F4A7C15);
    endfunction

    function automatic logic [255:0] line_data(logic [26:0] line);
        logic [255:0] d;
        for (int w = 0; w < 8; w++) d[w*32 +: 32] = mem_word(line, w);
        return d;
    endfunction

    function automatic logic [31:0] shape(logic [31:0] wd, int size, bit sgn, int boff);
        logic [7:0] b;
        logic [15:0] h;
        b = wd[8*boff +: 8];
        h = wd[16*(boff/2) +: 16];
        if (size == 0) return (sgn && b[7]) ? (32'hFFFFFF00 | 32'(b)) : 32'(b);
        if (size == 1) return (sgn && h[15]) ? (32'hFFFF0000 | 32'(h)) : 32'(h);
        return wd;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Advance to the next falling edge and observe registered outputs.
    task automatic tick();
        @(negedge clk);
        if (refill_req_valid) begin
            pend[refill_req_id]      = 1'b1;
            pend_line[refill_req_id] = refill_req_line;
        end
        if (done_valid) begin
            chk(exp_v[done_dest], "R6 completion for unknown dest", 64'(done_dest), 64'(done_dest));
            chk(done_data == exp_val[done_dest], "R7 replayed value", 64'(done_data), 64'(exp_val[done_dest]));
            exp_v[done_dest] = 1'b0;
        end
    endtask

    // Present a miss; record it in the model when accepted.
    task automatic try_miss(input logic [26:0] line, input int w, input int b, input int size,
                            input bit sgn, input int dest, output bit stalled);
        miss_valid  = 1'b1;
        miss_addr   = {line, 3'(w), 2'(b)};
        miss_dest   = 6'(dest);
        miss_size   = 2'(size);
        miss_signed = sgn;
        #1;
        stalled = stall;
        if (!stall) begin
            exp_v[dest]    = 1'b1;
            exp_line[dest] = line;
            exp_w[dest]    = w;
            exp_val[dest]  = shape(mem_word(line, w), size, sgn, b);
        end
    endtask

    task automatic respond(input int id);
        refill_rsp_valid = 1'b1;
        refill_rsp_id    = 2'(id);
        refill_rsp_data  = line_data(pend_line[id]);
        pend[id]         = 1'b0;
    endtask

    localparam logic [26:0] L0 = 27'h0001A2, L1 = 27'h0451B3, L2 = 27'h7FFFFF,
                            L3 = 27'h000000, L4 = 27'h123456;

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        bit st;
        int r;
        r = $urandom(32'h5EED1234);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(stall == 1'b0, "R1 stall after reset", 64'(stall), 0);
        chk(done_valid == 1'b0, "R1 done after reset", 64'(done_valid), 0);
        chk(refill_req_valid == 1'b0, "R1 request after reset", 64'(refill_req_valid), 0);

        // R2 primary miss: signed byte, word 5, byte 3
        try_miss(L0, 5, 3, 0, 1'b1, 1, st);
        chk(st == 1'b0, "R2 primary accepted", 64'(st), 0);
        tick();
        miss_valid = 1'b0;
        chk(refill_req_valid && refill_req_line == L0 && refill_req_id == 2'd0,
            "R2 refill request", {refill_req_valid, refill_req_id, refill_req_line}, {1'b1, 2'd0, L0});

        // R3 secondary miss: unsigned half, word 2, byte 2
        try_miss(L0, 2, 2, 1, 1'b0, 2, st);
        chk(st == 1'b0, "R3 secondary accepted", 64'(st), 0);
        tick();
        chk(refill_req_valid == 1'b0, "R3 no new request", 64'(refill_req_valid), 0);
        // R5 same word again
        try_miss(L0, 5, 0, 2, 1'b0, 3, st);
        chk(st == 1'b1, "R5 busy slot stalls", 64'(st), 1);
        tick();
        miss_valid = 1'b0;

        // fill entries 1..3
        for (int k = 0; k < 3; k++) begin
            try_miss(k == 0 ? L1 : (k == 1 ? L2 : L3), 0, 0, 2, 1'b0, 4 + k, st);
            tick();
            miss_valid = 1'b0;
            chk(refill_req_valid && refill_req_id == 2'(k + 1), "R2 lowest free entry",
                64'(refill_req_id), 64'(k + 1));
        end
        // R4 all live
        try_miss(L4, 1, 0, 2, 1'b0, 8, st);
        chk(st == 1'b1, "R4 full stalls", 64'(st), 1);
        tick();
        miss_valid = 1'b0;
        chk(refill_req_valid == 1'b0, "R4 no request when full", 64'(refill_req_valid), 0);

        // R8 out-of-order response to entry 2, R6 latency
        respond(2);
        tick();
        refill_rsp_valid = 1'b0;
        chk(done_valid == 1'b0, "R6 no completion at capture edge", 64'(done_valid), 0);
        tick();
        chk(done_valid && done_dest == 6'd5, "R8 completion for entry 2", 64'(done_dest), 5);
        tick();
        chk(done_valid == 1'b0, "R6 single slot then idle", 64'(done_valid), 0);

        // R6 order and R9 same-cycle free on entry 0
        respond(0);
        tick();
        refill_rsp_valid = 1'b0;
        tick();
        chk(done_valid && done_dest == 6'd2, "R6 lowest slot first", 64'(done_dest), 2);
        try_miss(L0, 7, 0, 2, 1'b0, 9, st);
        chk(st == 1'b0, "R9 miss on freeing entry accepted", 64'(st), 0);
        tick();
        miss_valid = 1'b0;
        chk(done_valid && done_dest == 6'd1, "R6 second slot next cycle", 64'(done_dest), 1);
        chk(refill_req_valid && refill_req_line == L0 && refill_req_id == 2'd2,
            "R9 reallocated as primary", {refill_req_valid, refill_req_id, refill_req_line}, {1'b1, 2'd2, L0});

        // random phase with bench memory
        for (int cyc = 0; cyc < 4000; cyc++) begin
            if ($urandom % 2 == 0) begin
                int s;
                s = $urandom % 4;
                for (int j = 0; j < 4; j++) begin
                    if (!refill_rsp_valid && pend[(s + j) % 4]) respond((s + j) % 4);
                end
            end
            if (cyc < 3500 && $urandom % 2 == 0) begin
                logic [26:0] ln;
                int w, dest, nl, nslot, s;
                bit lp, busy;
                bit seen [64];
                ln = 27'(($urandom % 6) * 32'h00A5F1);
                w = $urandom % 8;
                dest = -1;
                s = $urandom % 64;
                for (int j = 0; j < 64; j++) if (dest < 0 && !exp_v[(s + j) % 64]) dest = (s + j) % 64;
                nl = 0; nslot = 0; lp = 1'b0; busy = 1'b0;
                for (int d = 0; d < 64; d++) begin
                    seen[d] = 1'b0;
                    if (exp_v[d]) begin
                        bit first;
                        first = 1'b1;
                        for (int e = 0; e < d; e++) if (exp_v[e] && exp_line[e] == exp_line[d]) first = 1'b0;
                        if (first) nl++;
                        if (exp_line[d] == ln) begin
                            lp = 1'b1;
                            nslot++;
                            if (exp_w[d] == w) busy = 1'b1;
                        end
                    end
                end
                if (dest >= 0) begin
                    try_miss(ln, w, $urandom % 4, $urandom % 3, 1'($urandom), dest, st);
                    if (busy && nslot >= 2) chk(st == 1'b1, "R5 random busy slot", 64'(st), 1);
                    if (!lp && nl < 4) chk(st == 1'b0, "R2 random primary", 64'(st), 0);
                    if (!lp && nl == 4) chk(st == 1'b1, "R4 random full", 64'(st), 1);
                end
            end
            tick();
            miss_valid = 1'b0;
            refill_rsp_valid = 1'b0;
        end
        // drain
        for (int cyc = 0; cyc < 400; cyc++) begin
            for (int j = 0; j < 4; j++) if (!refill_rsp_valid && pend[j]) respond(j);
            tick();
            refill_rsp_valid = 1'b0;
        end
        begin
            int left;
            left = 0;
            for (int d = 0; d < 64; d++) if (exp_v[d]) left++;
            chk(left == 0, "R6 every load completed", 64'(left), 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule